// File: doc/BRIEF.md
# Quad-to-Double Precision Narrowing Converter

This block narrows one IEEE-754 binary128 operand to binary64 in a single registered stage. It unpacks the source, moves the exponent from the wide bias to the narrow one and keeps the top 52 fraction bits. The bits it discards are folded into a round bit and a sticky bit, and the result is rounded under one of the four standard directions. When an operation asks for it, round-to-odd is used instead. Results that fall below the binary64 normal range are shifted down into the subnormal range before rounding. Results that exceed the range saturate to infinity or to the largest finite value, depending on the rounding direction.

A host issues one conversion per cycle with `in_valid`, a two-bit rounding direction and a per-operation round-to-odd request. One cycle later the block returns a 128-bit destination word with the binary64 value in the upper doubleword and zeros below it. Alongside come four exception flags for that operation: inexact, overflow, underflow and invalid (signaling NaN). A four-bit sticky vector ORs every operation's flags together and is cleared only by reset.

Top module: `fp_narrow_q2d`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle, and all outputs are zero after reset. While `out_valid` is low, the four per-operation flags are zero.
- R2: The binary64 result occupies `out_res[127:64]` (sign at bit 127, exponent at 126:116, fraction at 115:64), and `out_res[63:0]` is always zero.
- R3: `in_rmode` selects the rounding direction: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. A rounding carry out of the fraction increments the exponent. `out_inexact` is set whenever any discarded source bit is nonzero.
- R4: When `in_odd` is 1, `in_rmode` is ignored and the fraction is truncated. Bit 64 of the result is then forced to 1 if any discarded bit was nonzero. An exact value is unchanged.
- R5: If the rebiased exponent reaches 2047, before or after rounding, both `out_overflow` and `out_inexact` are set. The result is infinity for nearest-even, for +infinity with a positive sign and for -infinity with a negative sign. In all other cases, including round-to-odd, the result is the largest finite magnitude with the source sign.
- R6: A finite source whose rebiased exponent is below 1, or a binary128 subnormal, is shifted into the binary64 subnormal range before rounding. Rounding may carry it up to the smallest normal. `out_underflow` is set exactly when the value is tiny before rounding and inexact.
- R7: A NaN source gives a NaN result with the sign kept, exponent all ones, fraction bit 51 (the quiet bit) set, and fraction bits 50:0 taken from source fraction bits 110:60. `out_invalid` is set only when source fraction bit 111 is 0 (signaling).
- R8: Signed zeros and infinities convert to the same signed zero or infinity and raise no flag.
- R9: `sticky_flags` holds {invalid, overflow, underflow, inexact} ORed over all operations since reset. It is updated in the same cycle as the operation's own flags, and no bit is ever cleared except by reset.
- R10: A finite in-range source with no nonzero discarded bits converts exactly, with the exponent rebiased and no flag raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 128 | binary128 source operand |
| in_rmode | input | 2 | Rounding direction (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| in_odd | input | 1 | Per-operation round-to-odd request |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 128 | binary64 result in bits 127:64, zeros below |
| out_inexact | output | 1 | Operation was inexact |
| out_overflow | output | 1 | Operation overflowed binary64 |
| out_underflow | output | 1 | Result was tiny and inexact |
| out_invalid | output | 1 | Source was a signaling NaN |
| sticky_flags | output | 4 | Accumulated {invalid, overflow, underflow, inexact} |

## Verification
The per-operation flags and the sticky accumulation update on the same clock edge. Several flags can also rise together, such as overflow with inexact or underflow with inexact. The bench streams conversions back to back, mixing exact, inexact, overflowing, tiny and signaling-NaN operands with no idle gaps. On every result it compares the flags of that operation and the sticky vector against a running OR kept in the scoreboard. A stale sticky bit, or a sticky bit lagging one cycle behind its flag, therefore shows up on the next compare.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
    localparam int SRC_EXP_W = 15;
    localparam int SRC_FRC_W = 112;
    localparam int DST_EXP_W = 11;
    localparam int DST_FRC_W = 52;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_TINY_IN,
        CL_FINITE,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } class_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;
endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int SEW = SRC_EXP_W,
    parameter int SFW = SRC_FRC_W,
    parameter int DEW = DST_EXP_W
) (
    input  logic [SEW+SFW:0]   op,
    output logic               sign,
    output class_e             cls,
    output logic signed [31:0] exp_adj,
    output logic [SFW-1:0]     frac
);
    localparam int GAP = ((1 << (SEW - 1)) - 1) - ((1 << (DEW - 1)) - 1);

    logic [SEW-1:0] bexp;

    assign sign = op[SEW+SFW];
    assign bexp = op[SFW +: SEW];
    assign frac = op[SFW-1:0];

    // Source exponent expressed in the destination's bias
    assign exp_adj = $signed({{(32-SEW){1'b0}}, bexp}) - GAP;

    always_comb begin
        if (bexp == '1) begin
            if (frac == '0)          cls = CL_INF;
            else if (frac[SFW-1])    cls = CL_QNAN;
            else                     cls = CL_SNAN;
        end else if (bexp == '0) begin
            cls = (frac == '0) ? CL_ZERO : CL_TINY_IN;
        end else begin
            cls = CL_FINITE;
        end
    end
endmodule

// File: rtl/fpn_align.sv
module fpn_align
    import fpn_pkg::*;
#(
    parameter int SFW = SRC_FRC_W,
    parameter int DEW = DST_EXP_W,
    parameter int DFW = DST_FRC_W
) (
    input  class_e              cls,
    input  logic signed [31:0]  exp_adj,
    input  logic [SFW-1:0]      frac,
    output logic [DEW+DFW-1:0]  field,
    output logic                rbit,
    output logic                sticky,
    output logic                tiny,
    output logic                ovf_pre
);
    localparam int EXT_W   = SFW + 1;
    localparam int DROP    = SFW - DFW;
    localparam int EXP_TOP = (1 << DEW) - 1;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] lostmask;
    logic [SFW-1:0]   shifted;
    logic [31:0]      sh;
    logic             lost;
    logic [DEW-1:0]   exp_field;
    logic [DFW-1:0]   keep;

    always_comb begin
        ext      = {1'b1, frac};
        tiny     = 1'b0;
        ovf_pre  = 1'b0;
        sh       = '0;
        lostmask = '0;
        if (cls == CL_FINITE) begin
            if (exp_adj >= EXP_TOP) ovf_pre = 1'b1;
            if (exp_adj < 1) begin
                tiny = 1'b1;
                sh   = 32'(1 - exp_adj);
            end
        end
        // Denormalize; the cast drops the hidden bit position
        if (sh >= 32'(EXT_W)) begin
            shifted = '0;
            lost    = 1'b1;
        end else begin
            shifted  = SFW'(ext >> sh);
            lostmask = ~({EXT_W{1'b1}} << sh);
            lost     = |(ext & lostmask);
        end
        keep      = shifted[SFW-1 -: DFW];
        rbit      = shifted[DROP-1];
        sticky    = (|shifted[DROP-2:0]) | lost;
        exp_field = (tiny || ovf_pre) ? '0 : exp_adj[DEW-1:0];
        if (cls == CL_TINY_IN) begin
            // Far below the narrow range: only a sticky remnant survives
            tiny      = 1'b1;
            keep      = '0;
            rbit      = 1'b0;
            sticky    = 1'b1;
            exp_field = '0;
        end
        field = {exp_field, keep};
    end
endmodule

// File: rtl/fpn_round.sv
module fpn_round
    import fpn_pkg::*;
#(
    parameter int DEW = DST_EXP_W,
    parameter int DFW = DST_FRC_W
) (
    input  logic               sign,
    input  class_e             cls,
    input  logic [DEW+DFW-1:0] field,
    input  logic               rbit,
    input  logic               sticky,
    input  logic               tiny,
    input  logic               ovf_pre,
    input  logic [1:0]         rmode,
    input  logic               odd,
    input  logic [DFW-2:0]     nan_pay,
    output logic [DEW+DFW:0]   res,
    output flags_t             flags
);
    localparam int FW = DEW + DFW;
    localparam logic [FW-1:0] MAX_FIN = {{(DEW-1){1'b1}}, 1'b0, {DFW{1'b1}}};
    localparam logic [FW-1:0] INF_MAG = {{DEW{1'b1}}, {DFW{1'b0}}};

    logic          inexact;
    logic          inc;
    logic          to_inf;
    logic          ovf;
    logic [FW-1:0] rounded;

    always_comb begin
        inexact = rbit | sticky;
        case (rmode)
            RM_NEAR_EVEN: inc = rbit & (sticky | field[0]);
            RM_TO_ZERO:   inc = 1'b0;
            RM_UP:        inc = ~sign & inexact;
            default:      inc = sign & inexact;
        endcase
        if (odd) inc = 1'b0;

        // Exponent and fraction form one word so a carry renormalizes
        rounded = field + FW'(inc);
        if (odd) rounded[0] = field[0] | inexact;

        ovf = ovf_pre | (rounded[FW-1 -: DEW] == '1);

        case (rmode)
            RM_NEAR_EVEN: to_inf = 1'b1;
            RM_TO_ZERO:   to_inf = 1'b0;
            RM_UP:        to_inf = ~sign;
            default:      to_inf = sign;
        endcase
        if (odd) to_inf = 1'b0;

        flags = '0;
        case (cls)
            CL_ZERO: res = {sign, {FW{1'b0}}};
            CL_INF:  res = {sign, INF_MAG};
            CL_QNAN, CL_SNAN: begin
                res           = {sign, {DEW{1'b1}}, 1'b1, nan_pay};
                flags.invalid = (cls == CL_SNAN);
            end
            default: begin
                if (ovf) begin
                    res            = {sign, to_inf ? INF_MAG : MAX_FIN};
                    flags.overflow = 1'b1;
                    flags.inexact  = 1'b1;
                end else begin
                    res             = {sign, rounded};
                    flags.inexact   = inexact;
                    flags.underflow = tiny & inexact;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp_narrow_q2d.sv
module fp_narrow_q2d
    import fpn_pkg::*;
#(
    parameter int SEW = SRC_EXP_W,
    parameter int SFW = SRC_FRC_W,
    parameter int DEW = DST_EXP_W,
    parameter int DFW = DST_FRC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SEW+SFW:0]     in_op,
    input  logic [1:0]           in_rmode,
    input  logic                 in_odd,
    output logic                 out_valid,
    output logic [SEW+SFW:0]     out_res,
    output logic                 out_inexact,
    output logic                 out_overflow,
    output logic                 out_underflow,
    output logic                 out_invalid,
    output logic [3:0]           sticky_flags
);
    localparam int SRC_W  = 1 + SEW + SFW;
    localparam int DST_W  = 1 + DEW + DFW;
    localparam int PAD_W  = SRC_W - DST_W;
    localparam int EXP_HI = SRC_W - 2;
    localparam int QBIT   = SRC_W - 2 - DEW;

    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] res;
        flags_t           flags;
        flags_t           sticky;
    } state_t;

    state_t st_d, st_q;

    logic               c_sign;
    class_e             c_cls;
    logic signed [31:0] c_exp;
    logic [SFW-1:0]     c_frac;
    logic [DEW+DFW-1:0] a_field;
    logic               a_rbit, a_sticky, a_tiny, a_ovf;
    logic [DST_W-1:0]   r_res;
    flags_t             r_flags;

    fpn_classify #(.SEW(SEW), .SFW(SFW), .DEW(DEW)) u_classify (
        .op(in_op), .sign(c_sign), .cls(c_cls), .exp_adj(c_exp), .frac(c_frac)
    );

    fpn_align #(.SFW(SFW), .DEW(DEW), .DFW(DFW)) u_align (
        .cls(c_cls), .exp_adj(c_exp), .frac(c_frac), .field(a_field),
        .rbit(a_rbit), .sticky(a_sticky), .tiny(a_tiny), .ovf_pre(a_ovf)
    );

    fpn_round #(.DEW(DEW), .DFW(DFW)) u_round (
        .sign(c_sign), .cls(c_cls), .field(a_field), .rbit(a_rbit),
        .sticky(a_sticky), .tiny(a_tiny), .ovf_pre(a_ovf), .rmode(in_rmode),
        .odd(in_odd), .nan_pay(c_frac[SFW-2 -: DFW-1]),
        .res(r_res), .flags(r_flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res    = r_res;
            st_d.flags  = r_flags;
            st_d.sticky = st_q.sticky | r_flags;
        end else begin
            st_d.res   = '0;
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_res       = {st_q.res, {PAD_W{1'b0}}};
    assign out_inexact   = st_q.flags.inexact;
    assign out_overflow  = st_q.flags.overflow;
    assign out_underflow = st_q.flags.underflow;
    assign out_invalid   = st_q.flags.invalid;
    assign sticky_flags  = st_q.sticky;

    // R1: one-cycle latency handshake
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_inexact | out_overflow | out_underflow | out_invalid));
    // R4: round-to-odd leaves an odd result whenever bits were lost
    assert_odd_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_odd) && out_inexact) |-> out_res[PAD_W]);
    // R5: overflow always reports inexact
    assert_ovf_inexact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_inexact);
    // R6: underflow only with inexact
    assert_ufl_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_underflow |-> out_inexact);
    // R7: a signaling source yields a quiet NaN
    assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_res[EXP_HI -: DEW] == '1) && out_res[QBIT]);
    // R9: accumulated flags never drop
    assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_flags & $past(sticky_flags)) == $past(sticky_flags));
endmodule

// File: tb/fp_narrow_q2d_tb.sv
module fp_narrow_q2d_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] FI = 4'b0001;
    localparam logic [3:0] FU = 4'b0010;
    localparam logic [3:0] FO = 4'b0100;
    localparam logic [3:0] FV = 4'b1000;

    localparam logic [111:0] B59    = 112'd1 << 59;
    localparam logic [111:0] B60    = 112'd1 << 60;
    localparam logic [111:0] B110   = 112'd1 << 110;
    localparam logic [111:0] B111   = 112'd1 << 111;
    localparam logic [111:0] ONES52 = {{52{1'b1}}, 60'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_op = '0;
    logic [1:0]   in_rmode = '0;
    logic         in_odd = 1'b0;
    logic         out_valid;
    logic [127:0] out_res;
    logic         out_inexact, out_overflow, out_underflow, out_invalid;
    logic [3:0]   sticky_flags;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_sticky = '0;

    logic [63:0] res_q[$];
    logic [3:0]  fl_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_narrow_q2d u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rmode(in_rmode), .in_odd(in_odd), .out_valid(out_valid),
        .out_res(out_res), .out_inexact(out_inexact), .out_overflow(out_overflow),
        .out_underflow(out_underflow), .out_invalid(out_invalid),
        .sticky_flags(sticky_flags)
    );

    function automatic logic [127:0] q(input logic s, input logic [14:0] e,
                                       input logic [111:0] f);
        return {s, e, f};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [127:0] op, input logic [1:0] rm, input logic odd,
                        input logic [63:0] er, input logic [3:0] ef, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_rmode = rm;
        in_odd   = odd;
        res_q.push_back(er);
        fl_q.push_back(ef);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each result, its flags and the running sticky OR
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R1 unexpected result", {127'd0, out_valid}, 128'd0);
                end else begin
                    logic [63:0] er;
                    logic [3:0]  ef;
                    string       tg;
                    er = res_q.pop_front();
                    ef = fl_q.pop_front();
                    tg = tag_q.pop_front();
                    exp_sticky = exp_sticky | ef;
                    check(out_res == {er, 64'd0}, {tg, " R2 result"}, out_res, {er, 64'd0});
                    check({out_invalid, out_overflow, out_underflow, out_inexact} == ef,
                          {tg, " flags"},
                          {124'd0, out_invalid, out_overflow, out_underflow, out_inexact},
                          {124'd0, ef});
                    check(sticky_flags == exp_sticky, {tg, " R9 sticky"},
                          {124'd0, sticky_flags}, {124'd0, exp_sticky});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_res == '0 && sticky_flags == '0,
              "R1 reset state", {out_valid, out_res[126:0]}, 128'd0);
        rst_n = 1'b1;

        // R10 exact conversions
        send(q(0, 15'h3FFF, 0),    2'd0, 0, 64'h3FF0000000000000, 4'd0, "R10 one");
        send(q(1, 15'h4000, B110), 2'd0, 0, 64'hC004000000000000, 4'd0, "R10 neg2.5");
        send(q(0, 15'h3C01, 0),    2'd0, 0, 64'h0010000000000000, 4'd0, "R10 min normal");
        // R3 rounding directions
        send(q(0, 15'h3FFF, B59), 2'd0, 0, 64'h3FF0000000000000, FI, "R3 tie even");
        send(q(0, 15'h3FFF, B59), 2'd2, 0, 64'h3FF0000000000001, FI, "R3 up pos");
        send(q(0, 15'h3FFF, B59), 2'd1, 0, 64'h3FF0000000000000, FI, "R3 zero");
        send(q(1, 15'h3FFF, B59), 2'd3, 0, 64'hBFF0000000000001, FI, "R3 down neg");
        send(q(1, 15'h3FFF, B59), 2'd2, 0, 64'hBFF0000000000000, FI, "R3 up neg");
        send(q(0, 15'h3FFF, B60 | B59), 2'd0, 0, 64'h3FF0000000000002, FI, "R3 tie odd");
        send(q(0, 15'h3FFF, B59 | 112'd1), 2'd0, 0, 64'h3FF0000000000001, FI, "R3 above tie");
        send(q(0, 15'h3FFF, ONES52 | B59), 2'd0, 0, 64'h4000000000000000, FI, "R3 carry");
        // R4 round-to-odd
        send(q(0, 15'h3FFF, B60 | B59), 2'd2, 1, 64'h3FF0000000000001, FI, "R4 odd over up");
        send(q(0, 15'h3FFF, B59), 2'd0, 1, 64'h3FF0000000000001, FI, "R4 odd force");
        send(q(0, 15'h3FFF, 0),   2'd0, 1, 64'h3FF0000000000000, 4'd0, "R4 odd exact");
        send(q(0, 15'h3FFF, B60 | 112'd1), 2'd0, 1, 64'h3FF0000000000001, FI, "R4 odd keep");
        // R5 overflow
        send(q(0, 15'h43FF, 0), 2'd0, 0, 64'h7FF0000000000000, FO | FI, "R5 near");
        send(q(0, 15'h43FF, 0), 2'd1, 0, 64'h7FEFFFFFFFFFFFFF, FO | FI, "R5 zero");
        send(q(1, 15'h43FF, 0), 2'd2, 0, 64'hFFEFFFFFFFFFFFFF, FO | FI, "R5 up neg");
        send(q(1, 15'h43FF, 0), 2'd3, 0, 64'hFFF0000000000000, FO | FI, "R5 down neg");
        send(q(0, 15'h43FF, 0), 2'd3, 0, 64'h7FEFFFFFFFFFFFFF, FO | FI, "R5 down pos");
        send(q(0, 15'h43FF, 0), 2'd0, 1, 64'h7FEFFFFFFFFFFFFF, FO | FI, "R5 odd");
        send(q(0, 15'h43FE, ONES52 | B59), 2'd0, 0, 64'h7FF0000000000000, FO | FI, "R5 post");
        send(q(0, 15'h43FE, ONES52 | B59), 2'd1, 0, 64'h7FEFFFFFFFFFFFFF, FI, "R5 edge");
        // R6 tiny results
        send(q(0, 15'h3C00, 0),   2'd0, 0, 64'h0008000000000000, 4'd0, "R6 exact sub");
        send(q(0, 15'h3C00, B60), 2'd0, 0, 64'h0008000000000000, FU | FI, "R6 sub tie");
        send(q(0, 15'h3C00, B60), 2'd2, 0, 64'h0008000000000001, FU | FI, "R6 sub up");
        send(q(0, 15'h3C00, ONES52), 2'd0, 0, 64'h0010000000000000, FU | FI, "R6 to normal");
        send(q(0, 15'h3BCC, 0), 2'd0, 0, 64'h0000000000000000, FU | FI, "R6 half min");
        send(q(0, 15'h3BCD, 0), 2'd0, 0, 64'h0000000000000001, 4'd0, "R6 min sub");
        send(q(0, 15'h0001, 0), 2'd0, 0, 64'h0000000000000000, FU | FI, "R6 deep");
        send(q(0, 15'h0001, 0), 2'd2, 0, 64'h0000000000000001, FU | FI, "R6 deep up");
        send(q(1, 15'h0000, 112'd1), 2'd3, 0, 64'h8000000000000001, FU | FI, "R6 src sub");
        send(q(0, 15'h0001, 0), 2'd1, 1, 64'h0000000000000001, FU | FI, "R6 deep odd");
        // R8 specials
        send(q(0, 15'h7FFF, 0), 2'd0, 0, 64'h7FF0000000000000, 4'd0, "R8 pos inf");
        send(q(1, 15'h7FFF, 0), 2'd2, 0, 64'hFFF0000000000000, 4'd0, "R8 neg inf");
        send(q(1, 15'h0000, 0), 2'd0, 0, 64'h8000000000000000, 4'd0, "R8 neg zero");
        send(q(0, 15'h0000, 0), 2'd3, 0, 64'h0000000000000000, 4'd0, "R8 pos zero");
        // R7 NaNs
        send(q(0, 15'h7FFF, B111 | B110), 2'd0, 0, 64'h7FFC000000000000, 4'd0, "R7 qnan");
        send(q(0, 15'h7FFF, B111 | (112'h5 << 60)), 2'd0, 0, 64'h7FF8000000000005, 4'd0,
             "R7 payload");
        send(q(0, 15'h7FFF, B110), 2'd0, 0, 64'h7FFC000000000000, FV, "R7 snan");
        send(q(1, 15'h7FFF, 112'd1), 2'd1, 1, 64'hFFF8000000000000, FV, "R7 snan low");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && !(out_inexact | out_overflow | out_underflow | out_invalid),
              "R1 idle", {123'd0, out_valid, out_inexact, out_overflow, out_underflow,
              out_invalid}, 128'd0);
        check(res_q.size() == 0, "R1 all results returned", 128'(res_q.size()), 128'd0);
        check(sticky_flags == 4'hF, "R9 final sticky", {124'd0, sticky_flags}, 128'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule